// File: doc/BRIEF.md
# Vector Clock Timestamp Unit

This block keeps a logical vector clock, so that transactions seen by several bus debug monitors can be put into a causal order after a run. There is one shared global timing vector with one counter field per participant. By default there are five participants: four bus masters and the arbiter. Each field is 32 bits wide, so the vector is 160 bits.

When a participant's monitor fires a trigger, the unit takes the latest global vector and adds one to that participant's own field. The result is written back as the new global vector. The same result is presented as that participant's local timing vector, together with a valid strobe and the participant's index, so that a recorder downstream can store it with the event.

Triggers that arrive together are queued in a pending mask. They are served one per cycle, lowest index first. Each stamp therefore sees every update that was granted before it.

Top module: `vclock_stamp_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every field of the global vector and of `stamp_vec_o` becomes zero, `stamp_valid_o` becomes low and all pending triggers are dropped.
- R2: A trigger sampled high on `trig_i[p]` at edge k, with no lower-index request pending, is granted in the cycle after edge k. `stamp_valid_o` is then high for exactly one cycle after edge k+1.
- R3: A granted update adds one to field p only, and leaves every other field at its current global value. Field i occupies bits `[i*FIELD_W +: FIELD_W]` of `stamp_vec_o`.
- R4: Each update starts from the latest global vector, so a later stamp includes the increments of all earlier grants.
- R5: While `stamp_valid_o` is high, `stamp_idx_o` holds the binary index p of the participant whose update is being reported.
- R6: When several participants have requests pending, exactly one is granted per cycle, and the lowest index goes first. Each request then produces its own stamp on consecutive cycles.
- R7: A field increment wraps modulo 2^FIELD_W, from all ones to zero, with no saturation. Other fields are not affected.
- R8: A trigger for a participant whose request is still pending and not yet granted merges into that request, giving one stamp. A trigger that arrives in the cycle its request is granted starts a new request.
- R9: In cycles without a valid stamp, `stamp_vec_o` holds the global vector unchanged and `stamp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | NUM_PART | One trigger bit per participant, sampled on each rising edge |
| stamp_valid_o | output | 1 | High for one cycle when a new local vector is reported |
| stamp_idx_o | output | IDX_W | Index of the participant that owns the reported vector |
| stamp_vec_o | output | NUM_PART*FIELD_W | Updated vector; this is also the current global vector |

## Verification
Two things can happen in the same cycle: a grant that writes the global vector back, and new triggers landing in the pending mask. The new trigger may come from the participant being granted or from one still waiting. The bench provokes this case with simultaneous trigger bursts, with retriggers of a participant that is still waiting behind a lower index, and with retriggers placed exactly in a grant cycle. It also adds sparse random trigger patterns. The bench judges each cycle against its own model of the pending mask and the vector. That model tells it whether each such retrigger should merge into an existing request or make a fresh stamp, and which field value each stamp must carry.

// File: rtl/vclock_pkg.sv
// Package: shared defaults for the vector clock timestamp unit.
// Assumes: consumers derive all widths from these values or from overrides.
package vclock_pkg;
    localparam int VC_DEF_PARTS   = 5;
    localparam int VC_DEF_FIELD_W = 32;

    // Width of a binary index able to address n participants.
    function automatic int vc_idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vclock_req_latch.sv
// Module: holds one pending request bit per participant.
// A trigger sets its bit and a grant clears it. A trigger in the grant
// cycle keeps the bit set, which makes a fresh request.
// Assumes: gnt_i is one-hot or zero and only marks pending bits.
module vclock_req_latch #(
    parameter int NUM_PART = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PART-1:0] trig_i,
    input  logic [NUM_PART-1:0] gnt_i,
    output logic [NUM_PART-1:0] pend_o
);
    logic [NUM_PART-1:0] pend_q;

    // Pending mask update: clear the served bit, then merge new triggers.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~gnt_i) | trig_i;
    end

    assign pend_o = pend_q;

    generate
        for (genvar i = 0; i < NUM_PART; i++) begin : g_chk
            // R8: a waiting request is never lost before it is granted.
            assert_pend_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[i] && !gnt_i[i]) |=> pend_q[i]);
        end
    endgenerate

    // R1: reset drops every pending request.
    assert_pend_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0));
endmodule

// File: rtl/vclock_prio_arb.sv
// Module: fixed-priority grant over the pending mask, lowest index wins.
// Purely combinational; it serves one participant per cycle.
// Assumes: IDX_W is wide enough to hold NUM_PART-1.
module vclock_prio_arb #(
    parameter int NUM_PART = 5,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PART-1:0] pend_i,
    output logic [NUM_PART-1:0] gnt_o,
    output logic                gnt_any_o,
    output logic [IDX_W-1:0]    gnt_idx_o
);
    // Isolate the lowest set bit of the pending mask.
    always_comb begin
        gnt_o = pend_i & (~pend_i + NUM_PART'(1));
    end

    // Encode the granted position as a binary index.
    always_comb begin
        gnt_idx_o = '0;
        for (int i = NUM_PART - 1; i >= 0; i--) begin
            if (pend_i[i]) gnt_idx_o = IDX_W'(i);
        end
    end

    assign gnt_any_o = |pend_i;

    // R6: at most one grant per cycle.
    assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    // R6: a grant only goes to a pending participant, and any pending one is served.
    assert_grant_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & ~pend_i) == '0) && ((pend_i != '0) == (gnt_o != '0)));
    // R6: no lower-index pending request is skipped.
    assert_grant_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any_o |-> ((pend_i & ((NUM_PART'(1) << gnt_idx_o) - NUM_PART'(1))) == '0));
endmodule

// File: rtl/vclock_gvec.sv
// Module: global timing vector and stamp strobe.
// On a grant it adds one to the owner's field, writes the result back,
// and reports it one cycle later as the local vector.
// Assumes: gnt_i is one-hot or zero and gnt_idx_i matches it.
module vclock_gvec #(
    parameter int NUM_PART = 5,
    parameter int FIELD_W  = 32,
    parameter int IDX_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PART-1:0]          gnt_i,
    input  logic                         gnt_any_i,
    input  logic [IDX_W-1:0]             gnt_idx_i,
    output logic                         stamp_valid_o,
    output logic [IDX_W-1:0]             stamp_idx_o,
    output logic [NUM_PART*FIELD_W-1:0]  stamp_vec_o
);
    logic [FIELD_W-1:0] glob_q [NUM_PART];
    logic               valid_q;
    logic [IDX_W-1:0]   idx_q;

    generate
        for (genvar i = 0; i < NUM_PART; i++) begin : g_field
            // Per-field counter: wrapping increment when its owner is granted.
            always_ff @(posedge clk) begin
                if (!rst_n)        glob_q[i] <= '0;
                else if (gnt_i[i]) glob_q[i] <= glob_q[i] + FIELD_W'(1);
            end

            assign stamp_vec_o[i*FIELD_W +: FIELD_W] = glob_q[i];

            // R3 R7: the owner's field moves by exactly one, modulo 2^FIELD_W.
            assert_field_bump_R3: assert property (@(posedge clk) disable iff (!rst_n)
                gnt_i[i] |=> (glob_q[i] == FIELD_W'($past(glob_q[i]) + FIELD_W'(1))));
            // R3 R9: a field without a grant keeps its value.
            assert_field_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !gnt_i[i] |=> $stable(glob_q[i]));
            // R1: reset clears the field.
            assert_field_reset_R1: assert property (@(posedge clk)
                !rst_n |=> (glob_q[i] == '0));
        end
    endgenerate

    // Stamp strobe and owner index, one cycle after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            valid_q <= gnt_any_i;
            if (gnt_any_i) idx_q <= gnt_idx_i;
        end
    end

    assign stamp_valid_o = valid_q;
    assign stamp_idx_o   = idx_q;

    // R2: the strobe follows each grant by one cycle.
    assert_valid_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any_i |=> stamp_valid_o);
    // R9: no strobe without a grant in the previous cycle.
    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_any_i |=> !stamp_valid_o);
    // R5: the reported index is the one granted.
    assert_idx_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any_i |=> (stamp_idx_o == $past(gnt_idx_i)));
endmodule

// File: rtl/vclock_stamp_unit.sv
// Module: top of the vector clock timestamp unit.
// Triggers are queued in a pending mask and served lowest index first,
// one per cycle. Each grant bumps the owner's field of the shared vector
// and reports the new vector with a strobe on the next cycle.
// Assumes: synchronous active-low reset; triggers are sampled every edge.
module vclock_stamp_unit
    import vclock_pkg::*;
#(
    parameter int NUM_PART = VC_DEF_PARTS,
    parameter int FIELD_W  = VC_DEF_FIELD_W,
    parameter int IDX_W    = vc_idx_width(NUM_PART)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PART-1:0]         trig_i,
    output logic                        stamp_valid_o,
    output logic [IDX_W-1:0]            stamp_idx_o,
    output logic [NUM_PART*FIELD_W-1:0] stamp_vec_o
);
    logic [NUM_PART-1:0] pend;
    logic [NUM_PART-1:0] gnt;
    logic                gnt_any;
    logic [IDX_W-1:0]    gnt_idx;

    vclock_req_latch #(.NUM_PART(NUM_PART)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .gnt_i  (gnt),
        .pend_o (pend)
    );

    vclock_prio_arb #(.NUM_PART(NUM_PART), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .gnt_o     (gnt),
        .gnt_any_o (gnt_any),
        .gnt_idx_o (gnt_idx)
    );

    vclock_gvec #(.NUM_PART(NUM_PART), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_gvec (
        .clk           (clk),
        .rst_n         (rst_n),
        .gnt_i         (gnt),
        .gnt_any_i     (gnt_any),
        .gnt_idx_i     (gnt_idx),
        .stamp_valid_o (stamp_valid_o),
        .stamp_idx_o   (stamp_idx_o),
        .stamp_vec_o   (stamp_vec_o)
    );

    // R2: a trigger with nothing pending shows up two edges later.
    assert_trig_to_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0 && trig_i[0]) |=> ##1 (stamp_valid_o && stamp_idx_o == '0));
endmodule

// File: tb/vclock_stamp_unit_bench.sv
`timescale 1ns/1ps
module vclock_stamp_unit_bench;
    localparam int N  = 5;
    localparam int FW = 6;
    localparam int IW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      trig = '0;
    logic              stamp_valid;
    logic [IW-1:0]     stamp_idx;
    logic [N*FW-1:0]   stamp_vec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // Reference model state, valid after the next rising edge.
    logic [N-1:0]  m_pend;
    logic [FW-1:0] m_glob [N];
    logic          m_valid;
    logic [IW-1:0] m_idx;

    always #2.5 clk = ~clk;

    vclock_stamp_unit #(.NUM_PART(N), .FIELD_W(FW), .IDX_W(IW)) u_vclock_stamp_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_i        (trig),
        .stamp_valid_o (stamp_valid),
        .stamp_idx_o   (stamp_idx),
        .stamp_vec_o   (stamp_vec)
    );

    function automatic logic [N*FW-1:0] flat_glob();
        logic [N*FW-1:0] v;
        for (int i = 0; i < N; i++) v[i*FW +: FW] = m_glob[i];
        return v;
    endfunction

    task automatic model_reset();
        m_pend = '0; m_valid = 1'b0; m_idx = '0;
        for (int i = 0; i < N; i++) m_glob[i] = '0;
    endtask

    // Advance the model over one edge with trigger vector t.
    task automatic model_edge(input logic [N-1:0] t);
        int g;
        g = -1;
        for (int i = N - 1; i >= 0; i--) if (m_pend[i]) g = i;
        m_valid = (g >= 0);
        if (g >= 0) begin
            m_idx = IW'(g);
            m_glob[g] = m_glob[g] + FW'(1);
            m_pend[g] = 1'b0;
        end
        m_pend = m_pend | t;
    endtask

    task automatic compare();
        checks++;
        if (stamp_valid !== m_valid) begin
            errors++;
            $display("FAIL %s valid actual %0b expected %0b", tag, stamp_valid, m_valid);
        end
        checks++;
        if (stamp_vec !== flat_glob()) begin
            errors++;
            $display("FAIL %s vector actual %h expected %h", tag, stamp_vec, flat_glob());
        end
        if (m_valid) begin
            checks++;
            if (stamp_idx !== m_idx) begin
                errors++;
                $display("FAIL %s index actual %0d expected %0d", tag, stamp_idx, m_idx);
            end
        end
    endtask

    task automatic step(input logic [N-1:0] t);
        @(negedge clk);
        compare();
        trig = t;
        model_edge(t);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0001));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: state after edges with reset held low.
        tag = "R1";
        compare();
        @(negedge clk);
        compare();
        rst_n = 1'b1;

        // R2 R3 R5: single trigger on participant 3, then idle.
        tag = "R2_R3_R5";
        step(5'b01000);
        step('0); step('0); step('0);

        // R4: chain of single triggers across participants.
        tag = "R4";
        step(5'b00001); step('0); step(5'b10000); step('0);
        step(5'b00010); step(5'b00100); step('0); step('0);

        // R6: all participants at once, served lowest first.
        tag = "R6";
        step(5'b11111);
        repeat (6) step('0);

        // R8: retrigger of waiting participant merges; retrigger in grant cycle is new.
        tag = "R8";
        step(5'b01011);
        step(5'b01000);
        step('0);
        step(5'b01000);
        repeat (4) step('0);

        // R7: wrap of one field past all ones.
        tag = "R7";
        for (int k = 0; k < 70; k++) begin
            step(5'b00100);
            step('0);
        end
        step('0);

        // R9: idle stretch keeps the vector.
        tag = "R9";
        repeat (5) step('0);

        // Random sparse and bursty triggers.
        tag = "R6_R8_rand";
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] t;
            t = '0;
            for (int b = 0; b < N; b++) t[b] = (($urandom % 4) == 0);
            step(t);
        end
        repeat (8) step('0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule